// File: doc/BRIEF.md
# Four-Channel DMA Controller Host Register File

This block is the processor-facing register file of a four-channel DMA controller that moves data through byte-wide ports. A host reaches it through an 8-bit write and read bus with a 4-bit register offset. Each channel has a 16-bit address register and a 16-bit count register. Each of these is a base and current pair. Because the bus is one byte wide, every 16-bit register is loaded by two byte writes. A single byte-order flip-flop, shared by all channels, decides which half of the register each byte goes to.

The block also holds a channel mask, a command byte, and a status byte whose upper nibble shows software transfer requests. It supports a master clear that returns the control state to a fixed set of values. The transfer engine reads the current registers, mask, command and status directly through dedicated output ports. The host reads status, mask and the temporary register through the bus.

Top module: `dmac_regfile`

## Requirements
- R1: After reset, all base and current address and count registers are zero, the mask is 0xF, the status and command bytes are 0x00, and the byte-order flip-flop is 0.
- R2: Writes to offsets 0 to 7 reach channel `offset[2:1]`. An even offset loads that channel's address register and an odd offset loads its count register. No other channel or register changes.
- R3: Every write to offsets 0 to 7 inverts the single byte-order flip-flop, whichever channel is addressed.
- R4: If the flip-flop is 1 after the inversion, the written byte becomes the whole base register and bits [15:8] become zero. If it is 0 after the inversion, the byte is ORed into bits [15:8] of the base register and bits [7:0] are kept.
- R5: After each byte write, the current register of the addressed channel and kind equals the new base value from the next cycle on.
- R6: A write to offset 9 targets channel `wdata[1:0]`. It sets status bit `4 + wdata[1:0]` when `wdata[2]` is 1 and clears that bit when `wdata[2]` is 0. No other status bit changes.
- R7: A write to offset 0xD clears the flip-flop, the status byte and the command byte, and sets the mask to 0xF. It does not change any base or current register.
- R8: A write to offset 0xE clears the mask to 0x0. Nothing else changes.
- R9: A write to offset 0xC clears the flip-flop. Nothing else changes.
- R10: A write to offset 8 loads the whole command byte. Writes to offsets 0xA, 0xB and 0xF change no state.
- R11: Reads are combinational on `bus_off`. Offset 8 returns the status byte, offset 0xD returns 0x00, offset 0xF returns `{4'b0, mask}`, and every other offset returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_off | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_off` |
| base_addr_o | output | 64 | Base address registers, channel n at bits [16n+15:16n] |
| cur_addr_o | output | 64 | Current address registers, same packing |
| base_cnt_o | output | 64 | Base count registers, same packing |
| cur_cnt_o | output | 64 | Current count registers, same packing |
| mask_o | output | 4 | Channel mask, bit n masks channel n |
| cmd_o | output | 8 | Command byte |
| status_o | output | 8 | Status byte, bits [7:4] are the request bits |
| byte_ptr_o | output | 1 | Byte-order flip-flop |

## Verification
Every register-backed result is due on the first rising edge after the write strobe. The bench drives a write on a falling edge, holds it across one rising edge, and compares all register outputs with its model one time step after the next falling edge. Read data has no register in its path, so a read is checked in the same half-cycle in which the offset is applied. Random writes are mixed with directed sequences. These include a first byte written on one channel and a second byte written on another, which exposes the shared flip-flop and the OR merge.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int NUM_CH = 4;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int OFF_W  = 4;

    localparam logic [OFF_W-1:0] OFF_CMD_STAT = 4'h8;
    localparam logic [OFF_W-1:0] OFF_REQ      = 4'h9;
    localparam logic [OFF_W-1:0] OFF_PTR_CLR  = 4'hC;
    localparam logic [OFF_W-1:0] OFF_MCLR     = 4'hD;
    localparam logic [OFF_W-1:0] OFF_MASK_CLR = 4'hE;
    localparam logic [OFF_W-1:0] OFF_MASK_RD  = 4'hF;

    localparam int REQ_FLAG_BIT = 2;
endpackage

// File: rtl/dmac_ctrl_regs.sv
module dmac_ctrl_regs
    import dmac_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [OFF_W-1:0]   off,
    input  logic [BUS_W-1:0]   wdata,
    output logic               ptr_next_o,
    output logic               ptr_o,
    output logic [NUM_CH-1:0]  mask_o,
    output logic [BUS_W-1:0]   cmd_o,
    output logic [2*NUM_CH-1:0] stat_o
);
    typedef struct packed {
        logic                ptr;
        logic [NUM_CH-1:0]   mask;
        logic [BUS_W-1:0]    cmd;
        logic [2*NUM_CH-1:0] stat;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr) begin
            if (!off[OFF_W-1]) begin
                ctl_d.ptr = ~ctl_q.ptr;
            end else begin
                unique case (off)
                    OFF_CMD_STAT: ctl_d.cmd = wdata;
                    OFF_REQ:      ctl_d.stat[NUM_CH + int'(wdata[CH_W-1:0])] = wdata[REQ_FLAG_BIT];
                    OFF_PTR_CLR:  ctl_d.ptr = 1'b0;
                    OFF_MCLR: begin
                        ctl_d.ptr  = 1'b0;
                        ctl_d.stat = '0;
                        ctl_d.cmd  = '0;
                        ctl_d.mask = '1;
                    end
                    OFF_MASK_CLR: ctl_d.mask = '0;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.ptr  <= 1'b0;
            ctl_q.mask <= '1;
            ctl_q.cmd  <= '0;
            ctl_q.stat <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ptr_next_o = ctl_d.ptr;
    assign ptr_o      = ctl_q.ptr;
    assign mask_o     = ctl_q.mask;
    assign cmd_o      = ctl_q.cmd;
    assign stat_o     = ctl_q.stat;

    // R3
    ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !off[OFF_W-1]) |=> (ptr_o != $past(ptr_o)));

    // R7
    master_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && off == OFF_MCLR) |=> (!ptr_o && stat_o == '0 && cmd_o == '0 && mask_o == '1));

    // R8
    mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && off == OFF_MASK_CLR) |=> (mask_o == '0 && $stable(stat_o) && $stable(cmd_o)));

    // R9
    ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && off == OFF_PTR_CLR) |=> (!ptr_o && $stable(mask_o) && $stable(stat_o) && $stable(cmd_o)));

    // R6
    request_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && off == OFF_REQ) |=>
            (stat_o[NUM_CH + int'($past(wdata[CH_W-1:0]))] == $past(wdata[REQ_FLAG_BIT])));

    // R6
    request_low_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_o[NUM_CH-1:0] == '0);
endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs #(
    parameter int REG_W = 16,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_addr,
    input  logic             wr_cnt,
    input  logic             ptr_next,
    input  logic [BUS_W-1:0] wdata,
    output logic [REG_W-1:0] base_addr_o,
    output logic [REG_W-1:0] cur_addr_o,
    output logic [REG_W-1:0] base_cnt_o,
    output logic [REG_W-1:0] cur_cnt_o
);
    typedef struct packed {
        logic [REG_W-1:0] base_addr;
        logic [REG_W-1:0] cur_addr;
        logic [REG_W-1:0] base_cnt;
        logic [REG_W-1:0] cur_cnt;
    } chan_t;

    chan_t ch_d, ch_q;

    function automatic logic [REG_W-1:0] merge_byte(
        input logic [REG_W-1:0] old_val,
        input logic             low_phase,
        input logic [BUS_W-1:0] b
    );
        logic [REG_W-1:0] wide;
        wide = REG_W'(b);
        if (low_phase) return wide;
        return old_val | (wide << BUS_W);
    endfunction

    always_comb begin
        ch_d = ch_q;
        if (wr_addr) begin
            ch_d.base_addr = merge_byte(ch_q.base_addr, ptr_next, wdata);
            ch_d.cur_addr  = ch_d.base_addr;
        end
        if (wr_cnt) begin
            ch_d.base_cnt = merge_byte(ch_q.base_cnt, ptr_next, wdata);
            ch_d.cur_cnt  = ch_d.base_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign base_addr_o = ch_q.base_addr;
    assign cur_addr_o  = ch_q.cur_addr;
    assign base_cnt_o  = ch_q.base_cnt;
    assign cur_cnt_o   = ch_q.cur_cnt;

    // R4
    first_byte_clears_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_addr && ptr_next) |=> (base_addr_o[REG_W-1:BUS_W] == '0));

    // R4
    second_byte_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt && !ptr_next) |=> (base_cnt_o[BUS_W-1:0] == $past(base_cnt_o[BUS_W-1:0])));

    // R5
    cur_addr_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_addr |=> (cur_addr_o == base_addr_o));

    // R5
    cur_cnt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cur_cnt_o == base_cnt_o));

    // R2
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_addr && !wr_cnt) |=> ($stable(base_addr_o) && $stable(base_cnt_o)));
endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
    import dmac_pkg::*;
#(
    parameter int REG_W = 16,
    parameter int BUS_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [OFF_W-1:0]        bus_off,
    input  logic [BUS_W-1:0]        bus_wdata,
    output logic [BUS_W-1:0]        bus_rdata,
    output logic [NUM_CH*REG_W-1:0] base_addr_o,
    output logic [NUM_CH*REG_W-1:0] cur_addr_o,
    output logic [NUM_CH*REG_W-1:0] base_cnt_o,
    output logic [NUM_CH*REG_W-1:0] cur_cnt_o,
    output logic [NUM_CH-1:0]       mask_o,
    output logic [BUS_W-1:0]        cmd_o,
    output logic [2*NUM_CH-1:0]     status_o,
    output logic                    byte_ptr_o
);
    logic ptr_next;

    dmac_ctrl_regs #(.BUS_W(BUS_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (bus_wr),
        .off        (bus_off),
        .wdata      (bus_wdata),
        .ptr_next_o (ptr_next),
        .ptr_o      (byte_ptr_o),
        .mask_o     (mask_o),
        .cmd_o      (cmd_o),
        .stat_o     (status_o)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        logic sel;
        assign sel = bus_wr && !bus_off[OFF_W-1] && (bus_off[CH_W:1] == CH_W'(ch));

        dmac_chan_regs #(.REG_W(REG_W), .BUS_W(BUS_W)) chan_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_addr     (sel && !bus_off[0]),
            .wr_cnt      (sel &&  bus_off[0]),
            .ptr_next    (ptr_next),
            .wdata       (bus_wdata),
            .base_addr_o (base_addr_o[ch*REG_W +: REG_W]),
            .cur_addr_o  (cur_addr_o [ch*REG_W +: REG_W]),
            .base_cnt_o  (base_cnt_o [ch*REG_W +: REG_W]),
            .cur_cnt_o   (cur_cnt_o  [ch*REG_W +: REG_W])
        );
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_off)
            OFF_CMD_STAT: bus_rdata = BUS_W'(status_o);
            OFF_MCLR:     bus_rdata = '0;
            OFF_MASK_RD:  bus_rdata = BUS_W'(mask_o);
            default:      bus_rdata = '0;
        endcase
    end

    // R11
    temp_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off == OFF_MCLR) |-> (bus_rdata == '0));

    // R10
    unused_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_off == 4'hA || bus_off == 4'hB || bus_off == OFF_MASK_RD)) |=>
            ($stable(mask_o) && $stable(cmd_o) && $stable(status_o) && $stable(byte_ptr_o)
             && $stable(base_addr_o) && $stable(base_cnt_o)));

    // R10
    cmd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_off == OFF_CMD_STAT) |=> (cmd_o == $past(bus_wdata)));
endmodule

// File: tb/dmac_regfile_tb.sv
module dmac_regfile_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_off = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [63:0] base_addr_o, cur_addr_o, base_cnt_o, cur_cnt_o;
    logic [3:0]  mask_o;
    logic [7:0]  cmd_o, status_o;
    logic        byte_ptr_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] m_ba [4];
    logic [15:0] m_bc [4];
    logic        m_ptr;
    logic [3:0]  m_mask;
    logic [7:0]  m_cmd, m_stat;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmac_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_off(bus_off),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .base_addr_o(base_addr_o), .cur_addr_o(cur_addr_o),
        .base_cnt_o(base_cnt_o), .cur_cnt_o(cur_cnt_o),
        .mask_o(mask_o), .cmd_o(cmd_o), .status_o(status_o), .byte_ptr_o(byte_ptr_o)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] merge(input logic [15:0] old, input logic ptr_after, input logic [7:0] b);
        if (ptr_after) return {8'h00, b};
        return old | {b, 8'h00};
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_ba[i] = '0;
            m_bc[i] = '0;
        end
        m_ptr = 1'b0; m_mask = 4'hF; m_cmd = '0; m_stat = '0;
    endtask

    task automatic model_write(input logic [3:0] off, input logic [7:0] d);
        int ch;
        ch = int'(off[2:1]);
        if (!off[3]) begin
            m_ptr = ~m_ptr;
            if (off[0]) m_bc[ch] = merge(m_bc[ch], m_ptr, d);
            else        m_ba[ch] = merge(m_ba[ch], m_ptr, d);
        end else begin
            case (off)
                4'h8: m_cmd = d;
                4'h9: m_stat[4 + int'(d[1:0])] = d[2];
                4'hC: m_ptr = 1'b0;
                4'hD: begin m_ptr = 1'b0; m_stat = '0; m_cmd = '0; m_mask = 4'hF; end
                4'hE: m_mask = 4'h0;
                default: ;
            endcase
        end
    endtask

    task automatic check_all(input string ctl_tag);
        for (int i = 0; i < 4; i++) begin
            chk("R4", $sformatf("base_addr[%0d]", i), 64'(base_addr_o[i*16 +: 16]), 64'(m_ba[i]));
            chk("R4", $sformatf("base_cnt[%0d]", i),  64'(base_cnt_o[i*16 +: 16]),  64'(m_bc[i]));
            chk("R5", $sformatf("cur_addr[%0d]", i),  64'(cur_addr_o[i*16 +: 16]),  64'(m_ba[i]));
            chk("R5", $sformatf("cur_cnt[%0d]", i),   64'(cur_cnt_o[i*16 +: 16]),   64'(m_bc[i]));
        end
        chk("R3", "byte_ptr", 64'(byte_ptr_o), 64'(m_ptr));
        chk(ctl_tag, "mask", 64'(mask_o), 64'(m_mask));
        chk(ctl_tag, "cmd", 64'(cmd_o), 64'(m_cmd));
        chk(ctl_tag, "status", 64'(status_o), 64'(m_stat));
    endtask

    task automatic do_write(input logic [3:0] off, input logic [7:0] d, input string tag);
        @(negedge clk);
        bus_wr = 1'b1; bus_off = off; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(off, d);
        #1;
        check_all(tag);
    endtask

    function automatic logic [7:0] exp_read(input logic [3:0] off);
        case (off)
            4'h8: return m_stat;
            4'hF: return {4'h0, m_mask};
            default: return 8'h00;
        endcase
    endfunction

    task automatic do_read(input logic [3:0] off);
        @(negedge clk);
        bus_off = off;
        #1;
        chk("R11", $sformatf("rdata@%h", off), 64'(bus_rdata), 64'(exp_read(off)));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [3:0] off;
        logic [7:0] d;
        void'($urandom(32'd20240517));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_all("R1");
        do_read(4'hF);

        // R2 R4: channel 2 address, two bytes
        do_write(4'h4, 8'h34, "R2");
        do_write(4'h4, 8'h12, "R2");
        chk("R2", "ch2 addr", 64'(base_addr_o[32 +: 16]), 64'h1234);
        // R3: first byte on ch1 count, second byte lands on ch3 count (OR into high)
        do_write(4'h3, 8'hAA, "R3");
        do_write(4'h7, 8'h5C, "R3");
        chk("R3", "ch3 cnt after shared ptr", 64'(base_cnt_o[48 +: 16]), 64'h5C00);
        // R4: OR merge onto existing high byte
        do_write(4'h4, 8'h0F, "R4");
        do_write(4'h2, 8'hF0, "R4");
        chk("R4", "ch1 addr or-merge", 64'(base_addr_o[16 +: 16]), 64'hF000);
        // R9: pointer clear mid-pair
        do_write(4'h0, 8'h77, "R9");
        do_write(4'hC, 8'hFF, "R9");
        do_write(4'h0, 8'h66, "R9");
        chk("R9", "ch0 addr restarted low", 64'(base_addr_o[0 +: 16]), 64'h0066);
        // R8, R10, R6
        do_write(4'hE, 8'h00, "R8");
        do_write(4'h8, 8'hA5, "R10");
        do_write(4'h9, 8'h06, "R6");
        do_write(4'h9, 8'h07, "R6");
        do_write(4'h9, 8'h02, "R6");
        chk("R6", "status", 64'(status_o), 64'h80);
        do_read(4'h8);
        do_write(4'hA, 8'hFF, "R10");
        do_write(4'hB, 8'hFF, "R10");
        do_write(4'hF, 8'h00, "R10");
        // R7
        do_write(4'hD, 8'h00, "R7");
        chk("R7", "mask after master clear", 64'(mask_o), 64'hF);
        do_read(4'hD);
        do_read(4'h0);

        for (int k = 0; k < 400; k++) begin
            off = 4'($urandom_range(0, 15));
            d   = 8'($urandom);
            if ($urandom_range(0, 4) == 0) do_read(off);
            else do_write(off, d, off[3] ? "R10" : "R2");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule